// File: doc/BRIEF.md
# Bus-Master DMA Register Engine

This block is a bus-master DMA engine for a disk interface. Software sees an eight-byte register window. It holds a command byte, a status byte and a 32-bit pointer to a table of transfer descriptors in memory. Setting the start bit makes the engine walk that table. It fetches each descriptor (a base address and a byte count), then moves the described words between memory and a word-wide device data stream. The direction comes from a command bit captured at start.

When the final descriptor has been drained and the device has signalled its own interrupt, the engine drops its active flag and raises its interrupt flag. A memory error response instead raises the error flag and halts the walk. Clearing the start bit aborts a walk at any point. The error and interrupt flags are cleared by writing ones. Two software-owned capability flags, one per attached drive, share the status byte.

Top module: `bmdma_engine`

## Requirements
- R1: Register window by byte offset. Offset 0 is the command byte: bit 0 is start, bit 3 is direction, and the other bits read 0. Offset 2 is the status byte. Offsets 4..7 hold the table pointer, least significant byte at offset 4, and pointer bits 1:0 always read 0. Offsets 1 and 3 read 0 whatever is written to them.
- R2: A command write with bit 0 = 1 while the stored start bit is 0 begins a walk at the table pointer. Status bit 0 (active) reads 1 from the next cycle until the walk ends.
- R3: A descriptor is two words: the address word at P and the count word at P+4. Count bits 15:2 give the byte count. A count of zero means 65536 bytes. Count bit 31 marks the final descriptor. The next descriptor sits at P+8.
- R4: With direction = 0, memory words are read at ascending addresses and presented on the device transmit stream in the same order. A word moves on a clock edge where both valid and ready are high.
- R5: With direction = 1, words taken from the device receive stream are written to memory at ascending addresses. The engine never offers to transmit and to receive in the same cycle.
- R6: Once the last word of the final descriptor has moved and a device interrupt has been seen during the walk, status bits 2:0 become 100 (interrupt 1, error 0, active 0). Until then the engine stays active.
- R7: A device interrupt that arrives before the table is finished is remembered but does not end the walk early. The interrupt flag rises only after the last word moves.
- R8: A memory response carrying an error sets status bit 1 and clears the active bit on the same edge. No further memory request follows.
- R9: A command write with bit 0 = 0 during a walk stops it. On the next cycle the active bit is 0, the interrupt flag is unchanged, and no memory or stream activity remains. A device interrupt while idle leaves the interrupt flag at 0.
- R10: Writing 1 to status bit 1 or bit 2 clears it, and writing 0 leaves it. Status bits 5 and 6 are read/write. Status bits 3, 4 and 7 read 0.
- R11: A memory request holds its address, direction and data stable until a response arrives, unless a stop intervenes.
- R12: The `irq` output always equals status bit 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register byte write strobe |
| reg_addr | input | 3 | Register byte offset |
| reg_wdata | input | 8 | Register write byte |
| reg_rdata | output | 8 | Register read byte for reg_addr (combinational) |
| mem_req | output | 1 | Memory request pending |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Word address of request |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with mem_rsp |
| mem_rsp | input | 1 | Response for the pending request |
| mem_err | input | 1 | Response carries an error |
| dev_tx_valid | output | 1 | Word offered to the device |
| dev_tx_data | output | 32 | Word to the device |
| dev_tx_ready | input | 1 | Device accepts the word |
| dev_rx_valid | input | 1 | Device offers a word |
| dev_rx_data | input | 32 | Word from the device |
| dev_rx_ready | output | 1 | Engine accepts a word |
| dev_irq | input | 1 | Device interrupt pulse |
| irq | output | 1 | Interrupt flag |

## Verification
A corrupted remaining-byte count or address pointer shows up at the ports within one descriptor. The bench observes it as a wrong word order, a word landing at the wrong memory address, or a completion that arrives a word early or late against the bench's own count of moved words. A lost or spurious record of the device interrupt shows in the cycles just after the last word moves: status either reaches 100 without an interrupt or stays active after one. A stale active state after a stop or an error shows on the very next cycle as a lingering memory request or stream handshake.

// File: rtl/bmdma_pkg.sv
// Shared definitions for the bus-master DMA engine: walker states,
// register byte offsets and bit positions inside command and status.
package bmdma_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,   // no walk in progress
        ST_FADDR,  // fetching descriptor address word
        ST_FCNT,   // fetching descriptor count word
        ST_MRD,    // reading one memory word for the device
        ST_TXW,    // offering that word on the transmit stream
        ST_RXW,    // waiting for a word from the device
        ST_MWR,    // writing the received word to memory
        ST_WIRQ    // table finished, waiting for device interrupt
    } walk_state_t;

    localparam int OFF_CMD = 0;
    localparam int OFF_STS = 2;
    localparam int OFF_PTR = 4;

    localparam int CMD_GO   = 0;
    localparam int CMD_DIR  = 3;
    localparam int STS_ACT  = 0;
    localparam int STS_ERR  = 1;
    localparam int STS_INT  = 2;
    localparam int STS_CAP0 = 5;
    localparam int STS_CAP1 = 6;

endpackage

// File: rtl/bmdma_regs.sv
// Register window of the DMA engine.
// Holds command, status flags, capability bits and the table pointer.
// Produces one-cycle start/stop pulses from command writes.
// Assumes: byte writes only, reads are combinational from stored state.
module bmdma_regs
    import bmdma_pkg::*;
#(
    parameter int PTR_W   = 32,
    parameter int RADDR_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr,
    input  logic [RADDR_W-1:0] reg_addr,
    input  logic [7:0]         reg_wdata,
    output logic [7:0]         reg_rdata,
    input  logic               walk_active,
    input  logic               walk_set_err,
    input  logic               walk_set_int,
    output logic               go_pulse,
    output logic               stop_pulse,
    output logic               go_dir,
    output logic [PTR_W-1:0]   tbl_base,
    output logic               sts_err,
    output logic               sts_int
);
    localparam int PTR_BYTES = PTR_W / 8;

    logic             cmd_go_q;
    logic             cmd_dir_q;
    logic [1:0]       cap_q;
    logic [PTR_W-1:0] ptr_q;
    logic             hit_cmd;
    logic             hit_sts;

    assign hit_cmd    = reg_wr && (reg_addr == RADDR_W'(OFF_CMD));
    assign hit_sts    = reg_wr && (reg_addr == RADDR_W'(OFF_STS));
    assign go_pulse   = hit_cmd && reg_wdata[CMD_GO] && !cmd_go_q;
    assign stop_pulse = hit_cmd && !reg_wdata[CMD_GO] && cmd_go_q;
    assign go_dir     = reg_wdata[CMD_DIR];
    assign tbl_base   = {ptr_q[PTR_W-1:2], 2'b00};

    // Command byte: start and direction bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_go_q  <= 1'b0;
            cmd_dir_q <= 1'b0;
        end else if (hit_cmd) begin
            cmd_go_q  <= reg_wdata[CMD_GO];
            cmd_dir_q <= reg_wdata[CMD_DIR];
        end
    end

    // Status flags: set from walker wins over write-one-to-clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sts_err <= 1'b0;
            sts_int <= 1'b0;
            cap_q   <= 2'b00;
        end else begin
            if (walk_set_err)
                sts_err <= 1'b1;
            else if (hit_sts && reg_wdata[STS_ERR])
                sts_err <= 1'b0;
            if (walk_set_int)
                sts_int <= 1'b1;
            else if (hit_sts && reg_wdata[STS_INT])
                sts_int <= 1'b0;
            if (hit_sts)
                cap_q <= {reg_wdata[STS_CAP1], reg_wdata[STS_CAP0]};
        end
    end

    // Table pointer bytes, least significant at the lowest offset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (reg_wr) begin
            for (int b = 0; b < PTR_BYTES; b++)
                if (reg_addr == RADDR_W'(OFF_PTR + b))
                    ptr_q[8*b +: 8] <= reg_wdata;
        end
    end

    // Read multiplexer; unmapped bits and offsets read zero.
    always_comb begin
        reg_rdata = '0;
        if (reg_addr == RADDR_W'(OFF_CMD)) begin
            reg_rdata[CMD_GO]  = cmd_go_q;
            reg_rdata[CMD_DIR] = cmd_dir_q;
        end else if (reg_addr == RADDR_W'(OFF_STS)) begin
            reg_rdata[STS_ACT]  = walk_active;
            reg_rdata[STS_ERR]  = sts_err;
            reg_rdata[STS_INT]  = sts_int;
            reg_rdata[STS_CAP0] = cap_q[0];
            reg_rdata[STS_CAP1] = cap_q[1];
        end else begin
            for (int b = 0; b < PTR_BYTES; b++)
                if (reg_addr == RADDR_W'(OFF_PTR + b))
                    reg_rdata = tbl_base[8*b +: 8];
        end
    end

endmodule

// File: rtl/bmdma_walker.sv
// Descriptor walker and data mover of the DMA engine.
// Fetches address/count pairs, moves words between memory and the device
// stream, then waits for the device interrupt before completing.
// Assumes: one outstanding memory request, counts are whole words,
// ADDR_W <= DATA_W.
module bmdma_walker
    import bmdma_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic              stop,
    input  logic              go_dir,
    input  logic [ADDR_W-1:0] tbl_base,
    input  logic              dev_irq,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_rsp,
    input  logic              mem_err,
    output logic              dev_tx_valid,
    output logic [DATA_W-1:0] dev_tx_data,
    input  logic              dev_tx_ready,
    input  logic              dev_rx_valid,
    input  logic [DATA_W-1:0] dev_rx_data,
    output logic              dev_rx_ready,
    output logic              active,
    output logic              set_err,
    output logic              set_int
);
    localparam int BYTES = DATA_W / 8;
    localparam int REM_W = CNT_W + 1;
    localparam logic [REM_W-1:0] FULL_CNT = {1'b1, {CNT_W{1'b0}}};

    walk_state_t       state_q;
    walk_state_t       after_word;
    logic [ADDR_W-1:0] tptr_q;
    logic [ADDR_W-1:0] cur_q;
    logic [REM_W-1:0]  rem_q;
    logic [DATA_W-1:0] buf_q;
    logic              eot_q;
    logic              dir_q;
    logic              irq_seen_q;
    logic              mem_ok;
    logic              mem_bad;
    logic [CNT_W-1:0]  cnt_field;

    assign mem_ok    = mem_req && mem_rsp && !mem_err;
    assign mem_bad   = mem_req && mem_rsp && mem_err;
    assign cnt_field = mem_rdata[CNT_W-1:0] & ~CNT_W'(BYTES - 1);
    assign active    = (state_q != ST_IDLE);
    assign set_err   = mem_bad && !stop;
    assign set_int   = (state_q == ST_WIRQ) && (irq_seen_q || dev_irq) && !stop;

    // Next state once a data word has fully moved.
    always_comb begin
        if (rem_q == REM_W'(BYTES))
            after_word = eot_q ? ST_WIRQ : ST_FADDR;
        else
            after_word = dir_q ? ST_RXW : ST_MRD;
    end

    // Memory and stream outputs decoded from the walker state.
    always_comb begin
        mem_req      = (state_q == ST_FADDR) || (state_q == ST_FCNT) ||
                       (state_q == ST_MRD)   || (state_q == ST_MWR);
        mem_we       = (state_q == ST_MWR);
        mem_wdata    = buf_q;
        dev_tx_valid = (state_q == ST_TXW);
        dev_tx_data  = buf_q;
        dev_rx_ready = (state_q == ST_RXW);
        case (state_q)
            ST_FADDR: mem_addr = tptr_q;
            ST_FCNT:  mem_addr = tptr_q + ADDR_W'(BYTES);
            default:  mem_addr = cur_q;
        endcase
    end

    // Walk sequencer: descriptor fetch, word moves, completion wait.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            tptr_q  <= '0;
            cur_q   <= '0;
            rem_q   <= '0;
            buf_q   <= '0;
            eot_q   <= 1'b0;
            dir_q   <= 1'b0;
        end else if (stop) begin
            state_q <= ST_IDLE;
        end else begin
            case (state_q)
                ST_IDLE: if (go) begin
                    state_q <= ST_FADDR;
                    tptr_q  <= tbl_base;
                    dir_q   <= go_dir;
                end
                ST_FADDR: if (mem_bad) state_q <= ST_IDLE;
                    else if (mem_ok) begin
                        cur_q   <= mem_rdata[ADDR_W-1:0] & ~ADDR_W'(BYTES - 1);
                        state_q <= ST_FCNT;
                    end
                ST_FCNT: if (mem_bad) state_q <= ST_IDLE;
                    else if (mem_ok) begin
                        rem_q   <= (cnt_field == '0) ? FULL_CNT : {1'b0, cnt_field};
                        eot_q   <= mem_rdata[DATA_W-1];
                        tptr_q  <= tptr_q + ADDR_W'(2 * BYTES);
                        state_q <= dir_q ? ST_RXW : ST_MRD;
                    end
                ST_MRD: if (mem_bad) state_q <= ST_IDLE;
                    else if (mem_ok) begin
                        buf_q   <= mem_rdata;
                        state_q <= ST_TXW;
                    end
                ST_TXW: if (dev_tx_ready) begin
                    cur_q   <= cur_q + ADDR_W'(BYTES);
                    rem_q   <= rem_q - REM_W'(BYTES);
                    state_q <= after_word;
                end
                ST_RXW: if (dev_rx_valid) begin
                    buf_q   <= dev_rx_data;
                    state_q <= ST_MWR;
                end
                ST_MWR: if (mem_bad) state_q <= ST_IDLE;
                    else if (mem_ok) begin
                        cur_q   <= cur_q + ADDR_W'(BYTES);
                        rem_q   <= rem_q - REM_W'(BYTES);
                        state_q <= after_word;
                    end
                ST_WIRQ: if (irq_seen_q || dev_irq) state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Remembers a device interrupt seen at any point of the current walk.
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq_seen_q <= 1'b0;
        else if (go && !active)
            irq_seen_q <= 1'b0;
        else if (dev_irq && active)
            irq_seen_q <= 1'b1;
    end

endmodule

// File: rtl/bmdma_engine.sv
// Top of the bus-master DMA engine: register window plus descriptor walker.
// Assumes: a single clock domain and a synchronous active-low reset.
module bmdma_engine
    import bmdma_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  reg_wr,
    input  logic [$clog2(OFF_PTR + ADDR_W/8)-1:0] reg_addr,
    input  logic [7:0]                            reg_wdata,
    output logic [7:0]                            reg_rdata,
    output logic                                  mem_req,
    output logic                                  mem_we,
    output logic [ADDR_W-1:0]                     mem_addr,
    output logic [DATA_W-1:0]                     mem_wdata,
    input  logic [DATA_W-1:0]                     mem_rdata,
    input  logic                                  mem_rsp,
    input  logic                                  mem_err,
    output logic                                  dev_tx_valid,
    output logic [DATA_W-1:0]                     dev_tx_data,
    input  logic                                  dev_tx_ready,
    input  logic                                  dev_rx_valid,
    input  logic [DATA_W-1:0]                     dev_rx_data,
    output logic                                  dev_rx_ready,
    input  logic                                  dev_irq,
    output logic                                  irq
);
    localparam int RADDR_W = $clog2(OFF_PTR + ADDR_W/8);

    logic              go_pulse;
    logic              stop_pulse;
    logic              go_dir;
    logic [ADDR_W-1:0] tbl_base;
    logic              walk_active;
    logic              walk_set_err;
    logic              walk_set_int;
    logic              sts_err;
    logic              sts_int;

    assign irq = sts_int;

    bmdma_regs #(.PTR_W(ADDR_W), .RADDR_W(RADDR_W)) u_regs (
        .clk, .rst_n, .reg_wr, .reg_addr, .reg_wdata, .reg_rdata,
        .walk_active, .walk_set_err, .walk_set_int,
        .go_pulse, .stop_pulse, .go_dir, .tbl_base, .sts_err, .sts_int
    );

    bmdma_walker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_walk (
        .clk, .rst_n,
        .go(go_pulse), .stop(stop_pulse), .go_dir, .tbl_base, .dev_irq,
        .mem_req, .mem_we, .mem_addr, .mem_wdata, .mem_rdata, .mem_rsp, .mem_err,
        .dev_tx_valid, .dev_tx_data, .dev_tx_ready,
        .dev_rx_valid, .dev_rx_data, .dev_rx_ready,
        .active(walk_active), .set_err(walk_set_err), .set_int(walk_set_int)
    );

endmodule

// File: rtl/bmdma_chk.sv
// Property checker for the DMA engine, attached by bind.
// Assumes default widths of the engine.
module bmdma_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        reg_wr,
    input logic [2:0]  reg_addr,
    input logic [7:0]  reg_wdata,
    input logic        mem_req,
    input logic        mem_we,
    input logic        mem_rsp,
    input logic        mem_err,
    input logic [31:0] mem_addr,
    input logic        dev_tx_valid,
    input logic        dev_rx_ready,
    input logic        irq,
    input logic        sts_act,
    input logic        sts_err
);
    logic stop_wr;
    assign stop_wr = reg_wr && (reg_addr == 3'd0) && !reg_wdata[0];

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_rsp && !stop_wr |=> mem_req && $stable(mem_addr) && $stable(mem_we)); // R11
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> !sts_act); // R6
    AST_ERR_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_rsp && mem_err && !stop_wr |=> !sts_act && sts_err); // R8
    AST_ONE_DIR: assert property (@(posedge clk) disable iff (!rst_n)
        !(dev_tx_valid && dev_rx_ready)); // R5
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !sts_act |-> !mem_req && !dev_tx_valid && !dev_rx_ready); // R9
    AST_STOP_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        stop_wr && sts_act |=> !sts_act && $stable(irq)); // R9
    AST_W1C_INT: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr && reg_addr == 3'd2 && reg_wdata[2] && !sts_act |=> !irq); // R10

endmodule

bind bmdma_engine bmdma_chk u_chk (
    .clk, .rst_n, .reg_wr, .reg_addr, .reg_wdata,
    .mem_req, .mem_we, .mem_rsp, .mem_err, .mem_addr,
    .dev_tx_valid, .dev_rx_ready, .irq,
    .sts_act(walk_active), .sts_err(sts_err)
);

// File: tb/bmdma_engine_bench.sv
module bmdma_engine_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic        mem_rsp = 1'b0, mem_err = 1'b0;
    logic        dev_tx_valid;
    logic [31:0] dev_tx_data;
    logic        dev_tx_ready = 1'b0;
    logic        dev_rx_valid = 1'b0;
    logic [31:0] dev_rx_data = '0;
    logic        dev_rx_ready;
    logic        dev_irq = 1'b0;
    logic        irq;

    always #4 clk = ~clk;

    bmdma_engine u_bmdma_engine (.*);

    int          n_tests = 0;
    int          n_fail  = 0;
    logic [31:0] mem [logic [31:0]];
    logic [31:0] tx_q [$];
    logic [31:0] exp_q [$];
    int          rx_idx = 0;
    bit          err_en = 0;
    logic [31:0] err_addr = '0;
    int          nd;
    int          lens [4];
    logic [1:0]  caps = 2'b11;
    localparam logic [31:0] TBL = 32'h0000_8000;

    function automatic logic [31:0] mem_rd(input logic [31:0] a);
        return mem.exists(a) ? mem[a] : (32'hDEAD_0000 ^ a);
    endfunction
    function automatic logic [31:0] rx_gen(input int i);
        return (32'(i) * 32'h9E37_79B1) ^ 32'h5A5A_0000;
    endfunction
    function automatic logic [31:0] data_base(input int d);
        return 32'h0010_0000 + (32'(d) << 18);
    endfunction
    function automatic logic [7:0] exp_sts(input bit act, input bit err, input bit intr);
        return {1'b0, caps, 2'b00, intr, err, act};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Memory responder: random latency, optional error address.
    initial forever begin
        @(negedge clk);
        mem_rsp = 1'b0;
        mem_err = 1'b0;
        if (mem_req && ($urandom % 4 != 0)) begin
            mem_rsp   = 1'b1;
            mem_err   = err_en && (mem_addr == err_addr);
            mem_rdata = mem_rd(mem_addr);
            if (mem_we && !mem_err) mem[mem_addr] = mem_wdata;
        end
    end

    // Device model: random ready/valid, records and generates words.
    initial forever begin
        @(negedge clk);
        dev_tx_ready = ($urandom % 4 != 0);
        if (dev_tx_valid && dev_tx_ready) tx_q.push_back(dev_tx_data);
        dev_rx_valid = ($urandom % 4 != 0);
        dev_rx_data  = rx_gen(rx_idx);
        if (dev_rx_valid && dev_rx_ready) rx_idx++;
    end

    task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask
    task automatic rd_reg(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask
    task automatic pulse_irq();
        @(negedge clk); dev_irq = 1'b1;
        @(negedge clk); dev_irq = 1'b0;
    endtask
    task automatic set_ptr(input logic [31:0] p);
        for (int b = 0; b < 4; b++) wr_reg(3'(4 + b), p[8*b +: 8]);
    endtask

    // Builds table and source data; direction 0 fills expected words.
    task automatic build(input bit dir);
        mem.delete(); tx_q.delete(); exp_q.delete(); rx_idx = 0;
        for (int d = 0; d < nd; d++) begin
            logic [31:0] cnt;
            cnt = (lens[d] == 16384) ? 32'h0 : 32'(lens[d] * 4);
            if (d == nd - 1) cnt[31] = 1'b1;
            mem[TBL + 32'(8 * d)]     = data_base(d);
            mem[TBL + 32'(8 * d + 4)] = cnt;
            if (!dir)
                for (int w = 0; w < lens[d]; w++) begin
                    logic [31:0] v;
                    v = $urandom;
                    mem[data_base(d) + 32'(4 * w)] = v;
                    exp_q.push_back(v);
                end
        end
        set_ptr(TBL);
    endtask

    task automatic wait_moved(input bit dir, input int total);
        for (int g = 0; g < 120000; g++) begin
            if ((dir ? rx_idx : tx_q.size()) >= total) break;
            @(negedge clk);
        end
    endtask

    task automatic run_xfer(input bit dir, input bit early, input string tag);
        logic [7:0] s;
        int total, bad, k;
        total = 0;
        for (int d = 0; d < nd; d++) total += lens[d];
        build(dir);
        wr_reg(3'd0, {4'b0, dir, 3'b000});
        wr_reg(3'd0, {4'b0, dir, 3'b001});
        if (early) begin
            pulse_irq();
            rd_reg(3'd2, s);
            chk({"R7 early irq keeps walk ", tag}, s, exp_sts(1, 0, 0));
        end else begin
            rd_reg(3'd2, s);
            chk({"R2 active during walk ", tag}, s, exp_sts(1, 0, 0));
        end
        wait_moved(dir, total);
        repeat (3) @(negedge clk);
        if (!early) begin
            rd_reg(3'd2, s);
            chk({"R6 waits for device irq ", tag}, s, exp_sts(1, 0, 0));
            pulse_irq();
            repeat (2) @(negedge clk);
        end
        rd_reg(3'd2, s);
        chk({"R6 completion status ", tag}, s, exp_sts(0, 0, 1));
        chk({"R12 irq output ", tag}, 32'(irq), 32'd1);
        bad = 0;
        if (!dir) begin
            if (tx_q.size() != exp_q.size()) bad++;
            else foreach (exp_q[i]) if (tx_q[i] !== exp_q[i]) bad++;
            chk({"R4 R3 transmit words ", tag}, bad, 0);
        end else begin
            k = 0;
            for (int d = 0; d < nd; d++)
                for (int w = 0; w < lens[d]; w++) begin
                    if (mem_rd(data_base(d) + 32'(4 * w)) !== rx_gen(k)) bad++;
                    k++;
                end
            chk({"R5 R3 received words in memory ", tag}, bad, 0);
            chk({"R5 receive count ", tag}, rx_idx, total);
        end
        wr_reg(3'd2, {1'b0, caps, 5'b00100});
        rd_reg(3'd2, s);
        chk({"R10 interrupt cleared by one ", tag}, s, exp_sts(0, 0, 0));
        chk({"R12 irq low after clear ", tag}, 32'(irq), 32'd0);
        wr_reg(3'd0, {4'b0, dir, 3'b000});
    endtask

    initial begin
        logic [7:0] s;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // Reset state and register window (R1, R10).
        rd_reg(3'd2, s); chk("R10 status after reset", s, 8'h00);
        rd_reg(3'd0, s); chk("R1 command after reset", s, 8'h00);
        chk("R11 no request after reset", 32'(mem_req), 32'd0);
        wr_reg(3'd0, 8'hF6); rd_reg(3'd0, s); chk("R1 command unused bits", s, 8'h00);
        wr_reg(3'd0, 8'hFE); rd_reg(3'd0, s); chk("R1 command direction bit", s, 8'h08);
        wr_reg(3'd0, 8'h00);
        wr_reg(3'd1, 8'hFF); rd_reg(3'd1, s); chk("R1 offset 1 reads zero", s, 8'h00);
        wr_reg(3'd3, 8'hFF); rd_reg(3'd3, s); chk("R1 offset 3 reads zero", s, 8'h00);
        wr_reg(3'd4, 8'h13); rd_reg(3'd4, s); chk("R1 pointer low bits zero", s, 8'h10);
        wr_reg(3'd7, 8'hA5); rd_reg(3'd7, s); chk("R1 pointer top byte", s, 8'hA5);
        wr_reg(3'd2, 8'hFF); rd_reg(3'd2, s); chk("R10 caps set, reserved zero", s, 8'h60);
        wr_reg(3'd2, 8'h00); rd_reg(3'd2, s); chk("R10 caps cleared", s, 8'h00);
        wr_reg(3'd2, 8'h60);

        // Directed runs.
        nd = 2; lens[0] = 3; lens[1] = 1; run_xfer(0, 0, "dir0 short");
        nd = 3; lens[0] = 5; lens[1] = 2; lens[2] = 7; run_xfer(1, 0, "dir1 three");
        nd = 2; lens[0] = 40; lens[1] = 40; run_xfer(0, 1, "early irq");

        // Random runs.
        for (int r = 0; r < 6; r++) begin
            nd = 1 + int'($urandom % 4);
            for (int d = 0; d < 4; d++) lens[d] = 1 + int'($urandom % 24);
            run_xfer(1'($urandom % 2), 1'(r == 3), $sformatf("random %0d", r));
        end

        // Zero count means 64 KB (R3).
        nd = 1; lens[0] = 16384; run_xfer(1, 0, "64KB");
        chk("R3 nothing past 64KB", 32'(mem.exists(data_base(0) + 32'h10000)), 32'd0);

        // Memory error on the second descriptor fetch (R8).
        nd = 2; lens[0] = 4; lens[1] = 4;
        build(0);
        err_en = 1; err_addr = TBL + 32'd8;
        wr_reg(3'd0, 8'h01);
        for (int g = 0; g < 2000; g++) begin
            rd_reg(3'd2, s);
            if (!s[0]) break;
        end
        chk("R8 error status", s, exp_sts(0, 1, 0));
        repeat (3) @(negedge clk);
        chk("R8 no request after error", 32'(mem_req), 32'd0);
        chk("R8 first descriptor moved", tx_q.size(), 4);
        err_en = 0;
        wr_reg(3'd2, {1'b0, caps, 5'b00000});
        rd_reg(3'd2, s); chk("R10 writing zero keeps error", s, exp_sts(0, 1, 0));
        wr_reg(3'd2, {1'b0, caps, 5'b00010});
        rd_reg(3'd2, s); chk("R10 error cleared by one", s, exp_sts(0, 0, 0));
        wr_reg(3'd0, 8'h00);

        // Stop during a walk (R9).
        nd = 1; lens[0] = 200;
        build(0);
        wr_reg(3'd0, 8'h01);
        repeat (30) @(negedge clk);
        wr_reg(3'd0, 8'h00);
        rd_reg(3'd2, s); chk("R9 stop clears active", s, exp_sts(0, 0, 0));
        chk("R9 no request after stop", 32'(mem_req), 32'd0);
        chk("R9 no transmit after stop", 32'(dev_tx_valid), 32'd0);
        pulse_irq();
        repeat (2) @(negedge clk);
        rd_reg(3'd2, s); chk("R9 idle device irq ignored", s, exp_sts(0, 0, 0));
        chk("R12 irq stays low", 32'(irq), 32'd0);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule